// File: doc/BRIEF.md
# Set-Flag Compare Unit

This block executes the compare instructions that produce the processor's single condition flag, which later conditional branches consult. Each cycle the decoder may present one compare: a 5-bit relation code, a left operand taken from a register, and a right operand. The right operand is either a second register value or a 16-bit immediate widened to the data width. The block evaluates the relation and stores the result in the flag register on the next clock edge. The general register file is never written.

The right operand is widened by one of two rules, and the relation code selects the rule. Equality and signed relations replicate the immediate's top bit. Unsigned relations fill the upper bits with zeros.

The new flag value is also driven out combinationally as a bypass. This lets a branch in the following stage use it without waiting for the register. Codes outside the defined set leave the flag alone and raise an illegal-instruction indication.

Top module: `cmpflag_unit`

## Requirements
- R1: While reset is active and on the first cycle after it, `flag_q` is 0.
- R2: Code 0 sets the flag when the operands are equal. Code 1 sets the flag when they differ.
- R3: Codes 2, 3, 4 and 5 compare the operands as unsigned numbers, testing for greater, greater-or-equal, less and less-or-equal respectively.
- R4: Codes 6, 7, 8 and 9 compare the operands as two's-complement numbers, testing for greater, greater-or-equal, less and less-or-equal respectively.
- R5: With `imm_sel` = 1 and code 0, 1 or 6 to 9, the right operand is the immediate sign-extended to the data width.
- R6: With `imm_sel` = 1 and code 2 to 5, the right operand is the immediate zero-extended to the data width.
- R7: A valid compare with a code from 10 to 31 raises `illegal` in the same cycle and leaves `flag_q` unchanged.
- R8: When `cmp_valid` is 0, `flag_q` holds its value and `illegal` is 0, whatever the other inputs are.
- R9: `flag_next` always equals the value that `flag_q` takes at the next rising clock edge. For a valid legal compare, this is the compare result, available in the same cycle.
- R10: With `imm_sel` = 0, the right operand is `opnd_b` and the immediate has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | A compare instruction is presented this cycle |
| imm_sel | input | 1 | 1: right operand comes from the immediate; 0: from `opnd_b` |
| cmp_code | input | 5 | Relation code (0 to 9 defined) |
| opnd_a | input | DATA_W | Left operand |
| opnd_b | input | DATA_W | Right operand for the register form |
| imm | input | IMM_W | Immediate for the immediate form |
| flag_q | output | 1 | Registered condition flag |
| flag_next | output | 1 | Bypass: the flag value for the next edge |
| illegal | output | 1 | Valid compare carried a reserved code |

## Verification
The embedded properties check four behaviours on every cycle:
- the registered flag always follows the bypass value;
- the flag is frozen on idle cycles and on reserved-code cycles;
- `illegal` stays low when no compare is presented;
- a widened immediate carries zero or sign upper bits, as its code requires.

Whether each relation gives the correct answer cannot be seen from those invariants. The directed scenarios show this by comparing the flag against an independent model. They cover equal operands, the sign boundary (0x7FFFFFFF against 0x80000000) and immediates with the top bit set. In that last case the signed and unsigned extensions give opposite answers.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;
   localparam int CMP_CODE_W = 5;

   typedef enum logic [CMP_CODE_W-1:0] {
      REL_EQ   = 5'd0,
      REL_NE   = 5'd1,
      REL_GT_U = 5'd2,
      REL_GE_U = 5'd3,
      REL_LT_U = 5'd4,
      REL_LE_U = 5'd5,
      REL_GT_S = 5'd6,
      REL_GE_S = 5'd7,
      REL_LT_S = 5'd8,
      REL_LE_S = 5'd9
   } rel_code_e;

   // unsigned relations take a zero-extended immediate
   function automatic logic rel_is_unsigned(input logic [CMP_CODE_W-1:0] c);
      return (c >= REL_GT_U) && (c <= REL_LE_U);
   endfunction

   function automatic logic rel_is_legal(input logic [CMP_CODE_W-1:0] c);
      return c <= REL_LE_S;
   endfunction
endpackage

// File: rtl/cmpflag_rhs_sel.sv
module cmpflag_rhs_sel
   import cmpflag_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic                  imm_sel,
   input  logic [CMP_CODE_W-1:0] cmp_code,
   input  logic [DATA_W-1:0]     opnd_b,
   input  logic [IMM_W-1:0]      imm,
   output logic [DATA_W-1:0]     rhs
);
   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_wide;
   logic              zero_ext;

   assign zero_ext = rel_is_unsigned(cmp_code);

   generate
      if (EXT_W == 0) begin : g_noext
         assign imm_wide = imm;
      end else begin : g_ext
         logic fill;
         assign fill     = zero_ext ? 1'b0 : imm[IMM_W-1];
         assign imm_wide = {{EXT_W{fill}}, imm};

         always_comb begin
            if (imm_sel && zero_ext)
               a_r6_zero_upper: assert (rhs[DATA_W-1:IMM_W] == '0);
            if (imm_sel && !zero_ext)
               a_r5_sign_upper: assert (rhs[DATA_W-1] == imm[IMM_W-1]);
         end
      end
   endgenerate

   assign rhs = imm_sel ? imm_wide : opnd_b;
endmodule

// File: rtl/cmpflag_relation.sv
module cmpflag_relation
   import cmpflag_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit SUB_CMP = 1'b1
) (
   input  logic [CMP_CODE_W-1:0] cmp_code,
   input  logic [DATA_W-1:0]     lhs,
   input  logic [DATA_W-1:0]     rhs,
   output logic                  hit
);
   localparam int MSB = DATA_W - 1;

   logic is_eq, lt_u, lt_s;

   assign is_eq = (lhs == rhs);

   generate
      if (SUB_CMP) begin : g_sub
         // one shared subtractor: borrow gives unsigned order
         logic [DATA_W:0] diff;
         assign diff = {1'b0, lhs} - {1'b0, rhs};
         assign lt_u = diff[DATA_W];
         assign lt_s = (lhs[MSB] != rhs[MSB]) ? lhs[MSB] : lt_u;
      end else begin : g_op
         assign lt_u = lhs < rhs;
         assign lt_s = $signed(lhs) < $signed(rhs);
      end
   endgenerate

   always_comb begin
      case (cmp_code)
         REL_EQ:   hit = is_eq;
         REL_NE:   hit = !is_eq;
         REL_GT_U: hit = !lt_u && !is_eq;
         REL_GE_U: hit = !lt_u;
         REL_LT_U: hit = lt_u;
         REL_LE_U: hit = lt_u || is_eq;
         REL_GT_S: hit = !lt_s && !is_eq;
         REL_GE_S: hit = !lt_s;
         REL_LT_S: hit = lt_s;
         REL_LE_S: hit = lt_s || is_eq;
         default:  hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
   import cmpflag_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 16,
   parameter bit SUB_CMP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmp_valid,
   input  logic                  imm_sel,
   input  logic [CMP_CODE_W-1:0] cmp_code,
   input  logic [DATA_W-1:0]     opnd_a,
   input  logic [DATA_W-1:0]     opnd_b,
   input  logic [IMM_W-1:0]      imm,
   output logic                  flag_q,
   output logic                  flag_next,
   output logic                  illegal
);
   generate
      if (IMM_W < 1 || DATA_W < IMM_W) begin : g_bad_width
         $error("cmpflag_unit: IMM_W must be 1..DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] rhs;
   logic              rel_hit;
   logic              code_ok;

   assign code_ok = rel_is_legal(cmp_code);

   cmpflag_rhs_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_rhs (
      .imm_sel  (imm_sel),
      .cmp_code (cmp_code),
      .opnd_b   (opnd_b),
      .imm      (imm),
      .rhs      (rhs)
   );

   cmpflag_relation #(.DATA_W(DATA_W), .SUB_CMP(SUB_CMP)) u_rel (
      .cmp_code (cmp_code),
      .lhs      (opnd_a),
      .rhs      (rhs),
      .hit      (rel_hit)
   );

   assign flag_next = (cmp_valid && code_ok) ? rel_hit : flag_q;
   assign illegal   = cmp_valid && !code_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_next;
   end

   // R9: register follows the bypass value
   a_r9_bypass_lands: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (flag_q == $past(flag_next)));

   // R7: reserved code freezes the flag
   a_r7_reserved_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && illegal) |=> $stable(flag_q));

   // R8: idle cycles freeze the flag
   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |=> $stable(flag_q));

   // R8: no illegal indication without a compare
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |-> !illegal);
endmodule

// File: tb/tb_cmpflag_unit.sv
`timescale 1ns/1ps
module tb_cmpflag_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmp_valid, imm_sel;
   logic [4:0]  cmp_code;
   logic [31:0] opnd_a, opnd_b;
   logic [15:0] imm;
   logic        flag_q, flag_next, illegal;

   int total = 0;
   int bad   = 0;
   logic exp_flag;

   always #2.5 clk = ~clk;

   cmpflag_unit dut (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .imm_sel(imm_sel),
      .cmp_code(cmp_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
      .flag_q(flag_q), .flag_next(flag_next), .illegal(illegal)
   );

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   function automatic logic model(input int code, input logic [31:0] a,
                                  input logic [31:0] b, input logic [15:0] im,
                                  input logic use_im);
      logic [31:0] r;
      if (!use_im)                    r = b;
      else if (code >= 2 && code <= 5) r = {16'h0000, im};
      else                            r = {{16{im[15]}}, im};
      case (code)
         0: return a == r;
         1: return a != r;
         2: return a > r;
         3: return a >= r;
         4: return a < r;
         5: return a <= r;
         6: return $signed(a) > $signed(r);
         7: return $signed(a) >= $signed(r);
         8: return $signed(a) < $signed(r);
         default: return $signed(a) <= $signed(r);
      endcase
   endfunction

   // one compare: bypass and illegal checked mid-cycle, register after edge
   task automatic run_cmp(input string req, input int code, input logic [31:0] a,
                          input logic [31:0] b, input logic [15:0] im,
                          input logic use_im);
      @(negedge clk);
      cmp_valid = 1'b1; imm_sel = use_im; cmp_code = code[4:0];
      opnd_a = a; opnd_b = b; imm = im;
      #1;
      if (code <= 9) exp_flag = model(code, a, b, im, use_im);
      check({req, " bypass (R9)"}, flag_next, exp_flag);
      check({req, " illegal flag (R7)"}, illegal, (code > 9));
      @(posedge clk); #1;
      check({req, " registered flag"}, flag_q, exp_flag);
      cmp_valid = 1'b0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0; cmp_valid = 1'b1; imm_sel = 1'b0; cmp_code = 5'd0;
      opnd_a = 32'h5; opnd_b = 32'h5; imm = 16'h0;
      repeat (3) @(posedge clk);
      #1; check("R1 during reset", flag_q, 1'b0);
      @(negedge clk); rst_n = 1'b1; cmp_valid = 1'b0;
      #1; check("R1 after reset", flag_q, 1'b0);
      exp_flag = 1'b0;
   endtask

   task automatic t_equality;
      run_cmp("R2 eq same",   0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0, 1'b0);
      run_cmp("R2 eq differ", 0, 32'h1, 32'h2, 16'h0, 1'b0);
      run_cmp("R2 ne differ", 1, 32'h1, 32'h2, 16'h0, 1'b0);
      run_cmp("R2 ne same",   1, 32'h7, 32'h7, 16'h0, 1'b0);
   endtask

   task automatic t_unsigned;
      for (int c = 2; c <= 5; c++) begin
         run_cmp("R3 big vs small", c, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0);
         run_cmp("R3 small vs big", c, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0, 1'b0);
         run_cmp("R3 equal",        c, 32'h1234_5678, 32'h1234_5678, 16'h0, 1'b0);
      end
   endtask

   task automatic t_signed;
      for (int c = 6; c <= 9; c++) begin
         run_cmp("R4 neg vs pos", c, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0);
         run_cmp("R4 pos vs neg", c, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0, 1'b0);
         run_cmp("R4 equal",      c, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 16'h0, 1'b0);
      end
   endtask

   task automatic t_imm_sign;
      run_cmp("R5 eq sext",  0, 32'hFFFF_8000, 32'h0, 16'h8000, 1'b1);
      run_cmp("R5 eq sext2", 0, 32'h0000_8000, 32'h0, 16'h8000, 1'b1);
      run_cmp("R5 lts sext", 8, 32'hFFFF_0000, 32'h0, 16'hFFFF, 1'b1);
      run_cmp("R5 gts sext", 6, 32'h0000_0000, 32'h0, 16'hFFFF, 1'b1);
   endtask

   task automatic t_imm_zero;
      run_cmp("R6 ltu zext", 4, 32'h0000_0001, 32'h0, 16'hFFFF, 1'b1);
      run_cmp("R6 geu zext", 3, 32'h0000_FFFF, 32'h0, 16'hFFFF, 1'b1);
      run_cmp("R6 gtu zext", 2, 32'h0001_0000, 32'h0, 16'hFFFF, 1'b1);
   endtask

   task automatic t_reg_ignores_imm;
      run_cmp("R10 reg form eq", 0, 32'h0000_0003, 32'h0000_0003, 16'h0009, 1'b0);
      run_cmp("R10 reg form ne", 1, 32'h0000_0003, 32'h0000_0003, 16'hFFFF, 1'b0);
   endtask

   task automatic t_reserved;
      run_cmp("R7 set flag", 0, 32'h1, 32'h1, 16'h0, 1'b0);
      run_cmp("R7 code 10",  10, 32'h1, 32'h2, 16'h0, 1'b0);
      run_cmp("R7 code 31",  31, 32'h0, 32'h0, 16'h0, 1'b1);
      run_cmp("R7 clear flag", 1, 32'h1, 32'h1, 16'h0, 1'b0);
      run_cmp("R7 code 17",  17, 32'h1, 32'h1, 16'h0, 1'b0);
   endtask

   task automatic t_idle;
      run_cmp("R8 set flag", 3, 32'h9, 32'h9, 16'h0, 1'b0);
      @(negedge clk);
      cmp_valid = 1'b0; cmp_code = 5'd1; opnd_a = 32'h9; opnd_b = 32'h9;
      #1;
      check("R8 idle illegal", illegal, 1'b0);
      check("R8 idle bypass",  flag_next, 1'b1);
      cmp_code = 5'd20; #1;
      check("R8 idle reserved code", illegal, 1'b0);
      repeat (2) @(posedge clk); #1;
      check("R8 idle flag held", flag_q, 1'b1);
   endtask

   initial begin
      #100000;
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_equality();
      t_unsigned();
      t_signed();
      t_imm_sign();
      t_imm_zero();
      t_reg_ignores_imm();
      t_reserved();
      t_idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule